// File: doc/BRIEF.md
# Power-Management Event and System-Control-Interrupt Unit

This unit is the power-management event core of a south bridge. It claims a 64-byte I/O window whose base address and on/off switch come from configuration inputs held elsewhere in the chip. Inside the window sit three 16-bit registers and a free-running counter: an event-status register, an event-enable register, a control register, and the power-management timer. Status bits latch hardware events and are cleared by writing ones to them.

A level system-control interrupt (`sci`) is raised while any of four event sources is both latched and enabled: timer overflow, global lock, power button and RTC alarm. A separate output, `tmr_arm`, reports when the next timer overflow would raise an interrupt. That happens only while the timer enable bit is set and the timer status bit is clear.

Accesses are 32 bits wide with four byte lanes, so the status and enable halves of the first dword can be written on their own. Register selection is a decode onto four named targets: EVT (dword 0), CTL (dword 1), TMR (dword 2) and NONE (every other dword of the window). Each target has a fixed read or write action.

Top module: `pm_sci_top`

## Requirements
- R1: After reset, status, enable and control are zero and `sci` is low. With `cfg_win_en` low, `io_hit` stays low.
- R2: The window base is the low 16 bits of `cfg_base` ANDed with 0xFFC0. When the window is enabled, `io_hit` is high for addresses from base to base+63 and low for addresses outside that range.
- R3: While `cfg_win_en` is low, writes change no register and reads return zero.
- R4: The register layout is fixed by window offset:
  - Offset 0x00: bits 15:0 hold status and bits 31:16 hold enable.
  - Offset 0x04: bits 15:0 hold control.
  - Offset 0x08: the timer, in the low bits.
  - Any other offset in the window reads zero.
- R5: Writing a 1 to a status bit clears it, for bytes whose lane enable is set (`io_be[1:0]` for status bits). Writing a 0 leaves the bit unchanged.
- R6: If a source event arrives in the same cycle as a clear of its status bit, the event wins and the bit stays set.
- R7: Only bit positions 0 (timer), 5 (global lock), 8 (power button) and 10 (RTC) exist in status and enable. Enable is written through `io_be[3:2]`, and all other bits read zero.
- R8: The timer advances by one every clock. When it steps from all ones to zero, it sets status bit 0.
- R9: `sci` is high exactly while some implemented bit is set in both status and enable. It goes low in the cycle after the causing status bit is cleared or its enable bit is dropped.
- R10: `tmr_arm` is high only while enable bit 0 is set and status bit 0 is clear.
- R11: Control is a 16-bit read/write register written per byte lane through `io_be[1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 32 | Configuration value holding the window base |
| cfg_win_en | input | 1 | Window decode enable |
| io_addr | input | ADDR_W | I/O byte address (dword aligned) |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_be | input | 4 | Byte-lane enables |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, zero when not selected |
| io_hit | output | 1 | Address falls in the enabled window |
| evt_gbl | input | 1 | Global-lock event pulse |
| evt_pwrbtn | input | 1 | Power-button event pulse |
| evt_rtc | input | 1 | RTC-alarm event pulse |
| sci | output | 1 | Level system-control interrupt |
| tmr_arm | output | 1 | Timer overflow would raise an interrupt |

## Verification
The bench builds the unit with TMR_W=12 and keeps the defaults ADDR_W=16 and WIN_BYTES=64. The narrower timer wraps after 4096 cycles, which lets the overflow path and the disarming of `tmr_arm` be observed directly. The register table and the event tests all finish long before the first wrap, so their status reads are not disturbed by a timer event. The window base is set from a configuration value with stray upper and low-order bits, which exercises the alignment mask at both edges of the window.

// File: rtl/pm_sci_pkg.sv
package pm_sci_pkg;
    localparam int unsigned REG_W   = 16;
    localparam int unsigned BUS_W   = 32;
    localparam int unsigned LANES   = BUS_W / 8;

    localparam int unsigned POS_TMR = 0;
    localparam int unsigned POS_GBL = 5;
    localparam int unsigned POS_PWR = 8;
    localparam int unsigned POS_RTC = 10;

    localparam logic [REG_W-1:0] IMPL_MASK =
        REG_W'((1 << POS_TMR) | (1 << POS_GBL) | (1 << POS_PWR) | (1 << POS_RTC));

    typedef enum logic [1:0] {
        REG_EVT  = 2'd0,
        REG_CTL  = 2'd1,
        REG_TMR  = 2'd2,
        REG_NONE = 2'd3
    } pm_reg_e;
endpackage

// File: rtl/pm_addr_decode.sv
module pm_addr_decode
    import pm_sci_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned WIN_BYTES = 64
) (
    input  logic [31:0]       cfg_base,
    input  logic              cfg_win_en,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              hit,
    output pm_reg_e           reg_sel
);
    localparam int unsigned OFF_W = $clog2(WIN_BYTES);
    localparam int unsigned DW_W  = OFF_W - 2;

    logic [DW_W-1:0] dword;
    logic            unused_bits;

    assign unused_bits = ^{cfg_base[31:ADDR_W], cfg_base[OFF_W-1:0], io_addr[1:0]};

    assign hit   = cfg_win_en && (io_addr[ADDR_W-1:OFF_W] == cfg_base[ADDR_W-1:OFF_W]);
    assign dword = io_addr[OFF_W-1:2];

    always_comb begin
        unique case (dword)
            DW_W'(0): reg_sel = REG_EVT;
            DW_W'(1): reg_sel = REG_CTL;
            DW_W'(2): reg_sel = REG_TMR;
            default:  reg_sel = REG_NONE;
        endcase
    end
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
    import pm_sci_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt_vec,
    input  logic [REG_W-1:0] sts_clr,
    input  logic [REG_W-1:0] en_wmask,
    input  logic [REG_W-1:0] en_wdata,
    output logic [REG_W-1:0] sts_q,
    output logic [REG_W-1:0] en_q
);
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (IMPL_MASK[i]) begin : g_impl
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sts_q[i] <= 1'b0;
                    en_q[i]  <= 1'b0;
                end else begin
                    // a new event outranks a clear in the same cycle
                    sts_q[i] <= evt_vec[i] | (sts_q[i] & ~sts_clr[i]);
                    if (en_wmask[i]) begin
                        en_q[i] <= en_wdata[i];
                    end
                end
            end
        end else begin : g_none
            logic unused_in;
            assign unused_in = evt_vec[i] ^ sts_clr[i] ^ en_wmask[i] ^ en_wdata[i];
            assign sts_q[i]  = 1'b0;
            assign en_q[i]   = 1'b0;
        end
    end
endmodule

// File: rtl/pm_timer.sv
module pm_timer #(
    parameter int unsigned TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [TMR_W-1:0] count_q,
    output logic             wrap
);
    assign wrap = &count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end
endmodule

// File: rtl/pm_sci_top.sv
module pm_sci_top
    import pm_sci_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned WIN_BYTES = 64,
    parameter int unsigned TMR_W     = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_base,
    input  logic              cfg_win_en,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [3:0]        io_be,
    input  logic [31:0]       io_wdata,
    output logic [31:0]       io_rdata,
    output logic              io_hit,
    input  logic              evt_gbl,
    input  logic              evt_pwrbtn,
    input  logic              evt_rtc,
    output logic              sci,
    output logic              tmr_arm
);
    pm_reg_e          reg_sel;
    logic             wr_evt;
    logic             wr_ctl;
    logic [REG_W-1:0] lo_mask;
    logic [REG_W-1:0] hi_mask;
    logic [REG_W-1:0] evt_vec;
    logic [REG_W-1:0] sts_clr;
    logic [REG_W-1:0] en_wmask;
    logic [REG_W-1:0] sts_q;
    logic [REG_W-1:0] en_q;
    logic [REG_W-1:0] ctl_q;
    logic [TMR_W-1:0] tmr_q;
    logic             tmr_wrap;

    pm_addr_decode #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_dec (
        .cfg_base   (cfg_base),
        .cfg_win_en (cfg_win_en),
        .io_addr    (io_addr),
        .hit        (io_hit),
        .reg_sel    (reg_sel)
    );

    pm_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_q (tmr_q),
        .wrap    (tmr_wrap)
    );

    assign lo_mask = {{8{io_be[1]}}, {8{io_be[0]}}};
    assign hi_mask = {{8{io_be[3]}}, {8{io_be[2]}}};
    assign wr_evt  = io_wr && io_hit && (reg_sel == REG_EVT);
    assign wr_ctl  = io_wr && io_hit && (reg_sel == REG_CTL);

    always_comb begin
        evt_vec          = '0;
        evt_vec[POS_TMR] = tmr_wrap;
        evt_vec[POS_GBL] = evt_gbl;
        evt_vec[POS_PWR] = evt_pwrbtn;
        evt_vec[POS_RTC] = evt_rtc;
    end

    assign sts_clr  = wr_evt ? (lo_mask & io_wdata[REG_W-1:0]) : '0;
    assign en_wmask = wr_evt ? hi_mask : '0;

    pm_evt_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_vec  (evt_vec),
        .sts_clr  (sts_clr),
        .en_wmask (en_wmask),
        .en_wdata (io_wdata[BUS_W-1:REG_W]),
        .sts_q    (sts_q),
        .en_q     (en_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_ctl) begin
            ctl_q <= (ctl_q & ~lo_mask) | (io_wdata[REG_W-1:0] & lo_mask);
        end
    end

    always_comb begin
        io_rdata = '0;
        if (io_rd && io_hit) begin
            unique case (reg_sel)
                REG_EVT:  io_rdata = {en_q, sts_q};
                REG_CTL:  io_rdata = {{(BUS_W-REG_W){1'b0}}, ctl_q};
                REG_TMR:  io_rdata = BUS_W'(tmr_q);
                REG_NONE: io_rdata = '0;
            endcase
        end
    end

    assign sci     = |(sts_q & en_q & IMPL_MASK);
    assign tmr_arm = en_q[POS_TMR] & ~sts_q[POS_TMR];
endmodule

// File: rtl/pm_sci_chk.sv
module pm_sci_chk #(
    parameter int unsigned TMR_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_win_en,
    input logic             wr_evt,
    input logic             clr_b8,
    input logic             evt_pwrbtn,
    input logic             sci,
    input logic             tmr_arm,
    input logic [15:0]      sts_q,
    input logic [15:0]      en_q,
    input logic [15:0]      ctl_q,
    input logic [TMR_W-1:0] tmr_q
);
    a_r3_closed_window_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_win_en |=> ($stable(en_q) && $stable(ctl_q)));

    a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && clr_b8 && !evt_pwrbtn) |=> !sts_q[8]);

    a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pwrbtn |=> sts_q[8]);

    a_r8_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q != '1) |=> (tmr_q == $past(tmr_q) + 1'b1));

    a_r8_wrap_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q == '1) |=> sts_q[0]);

    a_r9_no_enable_no_sci: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !sci);

    a_r10_pending_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        sts_q[0] |-> !tmr_arm);
endmodule

bind pm_sci_top pm_sci_chk #(.TMR_W(TMR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_win_en (cfg_win_en),
    .wr_evt     (wr_evt),
    .clr_b8     (io_be[1] & io_wdata[8]),
    .evt_pwrbtn (evt_pwrbtn),
    .sci        (sci),
    .tmr_arm    (tmr_arm),
    .sts_q      (sts_q),
    .en_q       (en_q),
    .ctl_q      (ctl_q),
    .tmr_q      (tmr_q)
);

// File: tb/pm_sci_top_tb_top.sv
module pm_sci_top_tb_top;
    localparam int unsigned TMR_W = 12;
    localparam logic [15:0] B = 16'hE040;

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [3:0]  be;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [15] = '{
        '{1'b0, 16'hE040, 4'h0, 32'h0,         32'h0},          // R1 all clear
        '{1'b1, 16'hE040, 4'hC, 32'hFFFF_0000, 32'h0},          // R7 enable all
        '{1'b0, 16'hE040, 4'h0, 32'h0,         32'h0521_0000},  // R7 impl bits
        '{1'b1, 16'hE040, 4'h8, 32'h0,         32'h0},          // R7 upper lane
        '{1'b0, 16'hE040, 4'h0, 32'h0,         32'h0021_0000},  // R7
        '{1'b1, 16'hE044, 4'h3, 32'h0000_BEEF, 32'h0},          // R11
        '{1'b0, 16'hE044, 4'h0, 32'h0,         32'h0000_BEEF},  // R11
        '{1'b1, 16'hE044, 4'h2, 32'h0000_1200, 32'h0},          // R11 one lane
        '{1'b0, 16'hE044, 4'h0, 32'h0,         32'h0000_12EF},  // R11
        '{1'b0, 16'hE050, 4'h0, 32'h0,         32'h0},          // R4 spare dword
        '{1'b0, 16'hE07C, 4'h0, 32'h0,         32'h0},          // R4 last dword
        '{1'b1, 16'hE03C, 4'hF, 32'hFFFF_FFFF, 32'h0},          // R2 below window
        '{1'b1, 16'hE080, 4'hF, 32'hFFFF_FFFF, 32'h0},          // R2 above window
        '{1'b0, 16'hE040, 4'h0, 32'h0,         32'h0021_0000},  // R2 unchanged
        '{1'b0, 16'hE044, 4'h0, 32'h0,         32'h0000_12EF}   // R2 unchanged
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_base = 32'h5A5A_E07F;
    logic        cfg_win_en = 1'b0;
    logic [15:0] io_addr = B;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [3:0]  io_be = 4'h0;
    logic [31:0] io_wdata = 32'h0;
    logic [31:0] io_rdata;
    logic        io_hit;
    logic        evt_gbl = 1'b0;
    logic        evt_pwrbtn = 1'b0;
    logic        evt_rtc = 1'b0;
    logic        sci;
    logic        tmr_arm;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pm_sci_top #(.TMR_W(TMR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_win_en(cfg_win_en),
        .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_be(io_be),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_hit(io_hit),
        .evt_gbl(evt_gbl), .evt_pwrbtn(evt_pwrbtn), .evt_rtc(evt_rtc),
        .sci(sci), .tmr_arm(tmr_arm)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        io_addr = a; io_be = be; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) evt_gbl = 1'b1;
        else if (which == 1) evt_pwrbtn = 1'b1;
        else evt_rtc = 1'b1;
        @(negedge clk);
        evt_gbl = 1'b0; evt_pwrbtn = 1'b0; evt_rtc = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [31:0] t0;
        logic [31:0] t1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 hit off while window disabled", {31'b0, io_hit}, 32'h0);
        chk("R1 sci low after reset", {31'b0, sci}, 32'h0);
        cfg_win_en = 1'b1;
        #1 chk("R2 hit at base", {31'b0, io_hit}, 32'h1);

        for (int i = 0; i < 15; i++) begin
            if (VECS[i].wr) begin
                wr(VECS[i].addr, VECS[i].be, VECS[i].data);
            end else begin
                rd(VECS[i].addr, d);
                chk($sformatf("R4 vector %0d", i), d, VECS[i].exp);
            end
        end

        io_addr = 16'hE03C; #1 chk("R2 below base misses", {31'b0, io_hit}, 32'h0);
        io_addr = 16'hE080; #1 chk("R2 past end misses", {31'b0, io_hit}, 32'h0);
        io_addr = 16'hE07C; #1 chk("R2 last dword hits", {31'b0, io_hit}, 32'h1);
        chk("R9 no pending event", {31'b0, sci}, 32'h0);
        chk("R10 armed with enable and no status", {31'b0, tmr_arm}, 32'h1);

        // R3 closed window
        cfg_win_en = 1'b0;
        wr(B, 4'hC, 32'hFFFF_0000);
        rd(B, d);
        chk("R3 read zero while closed", d, 32'h0);
        chk("R3 hit low while closed", {31'b0, io_hit}, 32'h0);
        cfg_win_en = 1'b1;
        rd(B, d);
        chk("R3 enable untouched", d, 32'h0021_0000);

        // power button: R5, R6, R9
        wr(B, 4'h8, 32'h0500_0000);
        pulse(1);
        rd(B, d);
        chk("R7 power button status", d, 32'h0521_0100);
        chk("R9 sci from power button", {31'b0, sci}, 32'h1);
        wr(B, 4'h3, 32'h0000_0000);
        rd(B, d);
        chk("R5 zero write keeps status", d & 32'hFFFF, 32'h0100);
        @(negedge clk);
        evt_pwrbtn = 1'b1; io_addr = B; io_be = 4'h3; io_wdata = 32'h0100; io_wr = 1'b1;
        @(negedge clk);
        evt_pwrbtn = 1'b0; io_wr = 1'b0;
        rd(B, d);
        chk("R6 event beats clear", d & 32'hFFFF, 32'h0100);
        @(negedge clk);
        io_addr = B; io_be = 4'h2; io_wdata = 32'h0100; io_wr = 1'b1;
        #1 chk("R9 sci held before clear edge", {31'b0, sci}, 32'h1);
        @(negedge clk);
        io_wr = 1'b0;
        #1 chk("R9 sci low after clear", {31'b0, sci}, 32'h0);
        rd(B, d);
        chk("R5 status cleared", d & 32'hFFFF, 32'h0);

        // global lock
        pulse(0);
        #1 chk("R9 sci from global lock", {31'b0, sci}, 32'h1);
        wr(B, 4'h1, 32'h0000_0020);
        #1 chk("R5 global lock cleared", {31'b0, sci}, 32'h0);

        // RTC, then drop its enable
        pulse(2);
        #1 chk("R9 sci from rtc", {31'b0, sci}, 32'h1);
        wr(B, 4'h8, 32'h0);
        #1 chk("R9 sci low after enable drop", {31'b0, sci}, 32'h0);
        rd(B, d);
        chk("R7 rtc status kept, enable gone", d, 32'h0021_0400);
        wr(B, 4'h2, 32'h0000_0400);

        // timer stepping
        @(negedge clk);
        io_addr = B + 16'h8; io_rd = 1'b1;
        #1 t0 = io_rdata;
        repeat (5) @(negedge clk);
        #1 t1 = io_rdata;
        io_rd = 1'b0;
        chk("R8 timer advances per clock", (t1 - t0) & 32'hFFF, 32'h5);

        // overflow
        wr(B, 4'h1, 32'h0000_0001);
        #1 chk("R10 armed before overflow", {31'b0, tmr_arm}, 32'h1);
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            #1;
            if (!tmr_arm) break;
        end
        io_addr = B; io_rd = 1'b1;
        #1 d = io_rdata;
        chk("R8 overflow sets status bit 0", d & 32'hFFFF, 32'h0001);
        io_addr = B + 16'h8;
        #1 d = io_rdata;
        io_rd = 1'b0;
        chk("R8 timer wrapped to zero", d, 32'h0);
        chk("R9 sci from timer", {31'b0, sci}, 32'h1);
        chk("R10 disarmed while pending", {31'b0, tmr_arm}, 32'h0);
        wr(B, 4'h1, 32'h0000_0001);
        #1 chk("R9 sci low after timer clear", {31'b0, sci}, 32'h0);
        chk("R10 rearmed", {31'b0, tmr_arm}, 32'h1);

        finish_run();
    end
endmodule